// File: doc/BRIEF.md
# Calendar Freeze and Shadow Synchronization Controller

This block sits between a register interface clocked by the bus clock and a calendar core clocked by a slow real-time clock. Software sets a request bit in the status word. The request crosses into the real-time domain, where a small state machine stops the calendar. A freeze indication then crosses back and appears as a read-only "active" flag. While that flag is high, writes to the time, date and prescaler configuration words are taken. Clearing the request lets the calendar run again.

In the other direction, the block keeps bus-domain shadow copies of the core's time and date words. The real-time state machine captures the core's live values on each calendar tick while running, and once more on leaving the frozen state. A toggle carries each capture across to the bus domain. There the shadows are copied and a "synced" flag is set. Software clears that flag by writing zero to it and then polls until hardware sets it again.

A sticky "initialized" flag records that a date with a nonzero year has been loaded. Software can use it to skip setup after a warm restart.

The real-time state machine has three states:
- RUN: the calendar counts, and captures happen on ticks.
- FROZEN: the calendar is held.
- RESUME: a single cycle that makes the exit capture.

Its transitions are:
- RUN to FROZEN when the synchronized request is high.
- FROZEN to RESUME when the request is low.
- RESUME to RUN unconditionally.

Top module: `rtc_freeze_sync`

## Requirements
- R1: The status word has the request at bit 7 (read/write), the active flag at bit 6 (read-only), synced at bit 5 and initialized at bit 4. Bits 3:0 read zero. After reset all status bits, configuration words and shadows are zero and freeze is low.
- R2: Writing status (select 0) with bit 7 set raises freeze after the request passes a two-flop synchronizer and the state machine goes from RUN to FROZEN. The active flag rises after freeze passes a two-flop synchronizer back. The active flag is still low in the cycle after the write.
- R3: Writes with select 1 (time), 2 (date) or 3 (prescaler) update the matching configuration output only while the active flag is high. The prescaler takes data bits 22:0. When the active flag is low these writes are ignored.
- R4: Writing status with bit 7 clear takes the state machine from FROZEN through RESUME to RUN. Freeze drops and the active flag falls.
- R5: A status write with bit 5 at zero clears synced. Writing bit 5 as one never sets it. If a shadow update lands in the same cycle as a clear, the update wins.
- R6: In RUN, each calendar tick captures the core's time and date. The shadows then take those values and synced is set.
- R7: In FROZEN, ticks are ignored: the shadows stay unchanged and synced stays low.
- R8: On leaving FROZEN, exactly one capture is made without a tick. The shadows take the core values and synced is set.
- R9: Initialized sets when an accepted date write has a nonzero year field (date bits 23:16). Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register interface clock |
| clk_rtc | input | 1 | Calendar clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Register write strobe (bus domain) |
| wr_sel | input | 2 | Write target: 0 status, 1 time, 2 date, 3 prescaler |
| wr_data | input | 32 | Write data |
| status_o | output | 8 | Status word |
| shadow_time_o | output | 32 | Bus-domain copy of core time |
| shadow_date_o | output | 32 | Bus-domain copy of core date |
| cfg_time_o | output | 32 | Time value to load into the core |
| cfg_date_o | output | 32 | Date value to load into the core |
| cfg_presc_o | output | 23 | Prescaler value for the core |
| cal_freeze_o | output | 1 | Stop the calendar (real-time domain) |
| cal_tick_i | input | 1 | Calendar advance pulse (real-time domain) |
| cal_time_i | input | 32 | Live core time |
| cal_date_i | input | 32 | Live core date |

## Verification
Configuration writes and synced clears land one bus cycle after the write strobe. The bench samples them at the following falling bus edge.

Results that cross the clock domains have a bounded latency rather than a fixed one:
- The active flag needs up to three real-time edges plus two or three bus edges.
- A shadow refresh needs one real-time edge plus three bus edges.

For each of these the bench first checks that the flag has not moved in the cycle after the stimulus. It then polls once per bus cycle up to a fixed limit above the worst case. A miss is reported as a failure. For the ignored-tick case, the bench waits past that limit and checks that nothing changed.

// File: rtl/rtc_freeze_sync_pkg.sv
package rtc_freeze_sync_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_FROZEN = 2'd1,
        ST_RESUME = 2'd2
    } cal_state_e;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_TIME   = 2'd1,
        SEL_DATE   = 2'd2,
        SEL_PRESC  = 2'd3
    } reg_sel_e;

    localparam int BIT_REQ  = 7;
    localparam int BIT_ACT  = 6;
    localparam int BIT_SYNC = 5;
    localparam int BIT_INIT = 4;
endpackage

// File: rtl/rtc_freeze_sync_bitsync.sv
module rtc_freeze_sync_bitsync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= '0;
                end else if (g == 0) begin
                    chain[g] <= d;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rtc_freeze_sync_cal_ctrl.sv
module rtc_freeze_sync_cal_ctrl
    import rtc_freeze_sync_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk_rtc,
    input  logic          rst_n,
    input  logic          req_s,
    input  logic          cal_tick,
    input  logic [DW-1:0] cal_time,
    input  logic [DW-1:0] cal_date,
    output logic          freeze,
    output logic [DW-1:0] hold_time,
    output logic [DW-1:0] hold_date,
    output logic          cap_tgl
);
    cal_state_e state, state_nx;
    logic       capture;

    always_ff @(posedge clk_rtc or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:    if (req_s)  state_nx = ST_FROZEN;
            ST_FROZEN: if (!req_s) state_nx = ST_RESUME;
            ST_RESUME: state_nx = ST_RUN;
            default:   state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        freeze  = 1'b0;
        capture = 1'b0;
        unique case (state)
            ST_RUN:    capture = cal_tick;
            ST_FROZEN: freeze  = 1'b1;
            ST_RESUME: capture = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk_rtc or negedge rst_n) begin
        if (!rst_n) begin
            hold_time <= '0;
            hold_date <= '0;
            cap_tgl   <= 1'b0;
        end else if (capture) begin
            hold_time <= cal_time;
            hold_date <= cal_date;
            cap_tgl   <= ~cap_tgl;
        end
    end

    AST_FREEZE_NEEDS_REQ: assert property (@(posedge clk_rtc) disable iff (!rst_n)
        $rose(freeze) |-> $past(req_s)); // R2
    AST_NO_CAPTURE_FROZEN: assert property (@(posedge clk_rtc) disable iff (!rst_n)
        !$stable(cap_tgl) |-> $past(!freeze)); // R7
    AST_EXIT_CAPTURE: assert property (@(posedge clk_rtc) disable iff (!rst_n)
        $fell(freeze) |=> !$stable(cap_tgl)); // R8
endmodule

// File: rtl/rtc_freeze_sync_bus_regs.sv
module rtc_freeze_sync_bus_regs
    import rtc_freeze_sync_pkg::*;
#(
    parameter int DW       = 32,
    parameter int PW       = 23,
    parameter int YEAR_LSB = 16,
    parameter int YEAR_W   = 8
) (
    input  logic          clk_bus,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          active_s,
    input  logic          tgl_s,
    input  logic [DW-1:0] hold_time,
    input  logic [DW-1:0] hold_date,
    output logic          init_req,
    output logic          synced,
    output logic          inited,
    output logic [DW-1:0] cfg_time,
    output logic [DW-1:0] cfg_date,
    output logic [PW-1:0] cfg_presc,
    output logic [DW-1:0] shadow_time,
    output logic [DW-1:0] shadow_date
);
    logic tgl_d;
    logic upd;
    logic wr_status, wr_time, wr_date, wr_presc;

    assign upd       = tgl_s ^ tgl_d;
    assign wr_status = wr_en && (wr_sel == SEL_STATUS);
    assign wr_time   = wr_en && (wr_sel == SEL_TIME)  && active_s;
    assign wr_date   = wr_en && (wr_sel == SEL_DATE)  && active_s;
    assign wr_presc  = wr_en && (wr_sel == SEL_PRESC) && active_s;

    always_ff @(posedge clk_bus or negedge rst_n) begin
        if (!rst_n) begin
            init_req <= 1'b0;
            synced   <= 1'b0;
            inited   <= 1'b0;
            tgl_d    <= 1'b0;
        end else begin
            tgl_d <= tgl_s;
            if (wr_status) init_req <= wr_data[BIT_REQ];
            if (upd) synced <= 1'b1;
            else if (wr_status && !wr_data[BIT_SYNC]) synced <= 1'b0;
            if (wr_date && (wr_data[YEAR_LSB +: YEAR_W] != '0)) inited <= 1'b1;
        end
    end

    always_ff @(posedge clk_bus or negedge rst_n) begin
        if (!rst_n) begin
            cfg_time  <= '0;
            cfg_date  <= '0;
            cfg_presc <= '0;
        end else begin
            if (wr_time)  cfg_time  <= wr_data;
            if (wr_date)  cfg_date  <= wr_data;
            if (wr_presc) cfg_presc <= wr_data[PW-1:0];
        end
    end

    always_ff @(posedge clk_bus or negedge rst_n) begin
        if (!rst_n) begin
            shadow_time <= '0;
            shadow_date <= '0;
        end else if (upd) begin
            shadow_time <= hold_time;
            shadow_date <= hold_date;
        end
    end

    AST_CFG_ONLY_ACTIVE: assert property (@(posedge clk_bus) disable iff (!rst_n)
        !$stable(cfg_time) || !$stable(cfg_date) || !$stable(cfg_presc) |-> $past(active_s)); // R3
    AST_INITED_STICKY: assert property (@(posedge clk_bus) disable iff (!rst_n)
        !$fell(inited)); // R9
    AST_SYNC_FROM_UPDATE: assert property (@(posedge clk_bus) disable iff (!rst_n)
        $rose(synced) |-> $past(tgl_s != tgl_d)); // R5
    AST_SHADOW_FROM_UPDATE: assert property (@(posedge clk_bus) disable iff (!rst_n)
        !$stable(shadow_time) || !$stable(shadow_date) |-> $past(tgl_s != tgl_d)); // R6
endmodule

// File: rtl/rtc_freeze_sync.sv
module rtc_freeze_sync
    import rtc_freeze_sync_pkg::*;
#(
    parameter int DW       = 32,
    parameter int PW       = 23,
    parameter int YEAR_LSB = 16,
    parameter int YEAR_W   = 8,
    parameter int STAGES   = 2
) (
    input  logic          clk_bus,
    input  logic          clk_rtc,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [7:0]    status_o,
    output logic [DW-1:0] shadow_time_o,
    output logic [DW-1:0] shadow_date_o,
    output logic [DW-1:0] cfg_time_o,
    output logic [DW-1:0] cfg_date_o,
    output logic [PW-1:0] cfg_presc_o,
    output logic          cal_freeze_o,
    input  logic          cal_tick_i,
    input  logic [DW-1:0] cal_time_i,
    input  logic [DW-1:0] cal_date_i
);
    logic          init_req, req_s, freeze, active_s;
    logic          cap_tgl, tgl_s;
    logic          synced, inited;
    logic [DW-1:0] hold_time, hold_date;

    rtc_freeze_sync_bitsync #(.STAGES(STAGES), .W(1)) u_req_sync (
        .clk(clk_rtc), .rst_n(rst_n), .d(init_req), .q(req_s));

    rtc_freeze_sync_cal_ctrl #(.DW(DW)) u_cal (
        .clk_rtc(clk_rtc), .rst_n(rst_n), .req_s(req_s), .cal_tick(cal_tick_i),
        .cal_time(cal_time_i), .cal_date(cal_date_i), .freeze(freeze),
        .hold_time(hold_time), .hold_date(hold_date), .cap_tgl(cap_tgl));

    rtc_freeze_sync_bitsync #(.STAGES(STAGES), .W(2)) u_back_sync (
        .clk(clk_bus), .rst_n(rst_n), .d({freeze, cap_tgl}), .q({active_s, tgl_s}));

    rtc_freeze_sync_bus_regs #(.DW(DW), .PW(PW), .YEAR_LSB(YEAR_LSB), .YEAR_W(YEAR_W)) u_bus (
        .clk_bus(clk_bus), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .active_s(active_s), .tgl_s(tgl_s), .hold_time(hold_time), .hold_date(hold_date),
        .init_req(init_req), .synced(synced), .inited(inited),
        .cfg_time(cfg_time_o), .cfg_date(cfg_date_o), .cfg_presc(cfg_presc_o),
        .shadow_time(shadow_time_o), .shadow_date(shadow_date_o));

    always_comb begin
        status_o           = '0;
        status_o[BIT_REQ]  = init_req;
        status_o[BIT_ACT]  = active_s;
        status_o[BIT_SYNC] = synced;
        status_o[BIT_INIT] = inited;
    end

    assign cal_freeze_o = freeze;

    AST_ACTIVE_NEEDS_REQ: assert property (@(posedge clk_bus) disable iff (!rst_n)
        $rose(status_o[BIT_ACT]) |-> status_o[BIT_REQ] || $past(status_o[BIT_REQ])); // R2
endmodule

// File: tb/rtc_freeze_sync_test.sv
module rtc_freeze_sync_test;
    localparam int BUS_PERIOD = 10;
    localparam int RTC_PERIOD = 36;
    localparam int WAIT_MAX   = 40;

    logic        clk_bus = 0, clk_rtc = 0, rst_n = 0;
    logic        wr_en = 0;
    logic [1:0]  wr_sel = 0;
    logic [31:0] wr_data = 0;
    logic [7:0]  status_o;
    logic [31:0] shadow_time_o, shadow_date_o, cfg_time_o, cfg_date_o;
    logic [22:0] cfg_presc_o;
    logic        cal_freeze_o;
    logic        cal_tick_i = 0;
    logic [31:0] cal_time_i = 0, cal_date_i = 0;

    int checks = 0, fails = 0;
    bit ok;

    always #(BUS_PERIOD/2) clk_bus = ~clk_bus;
    always #(RTC_PERIOD/2) clk_rtc = ~clk_rtc;

    rtc_freeze_sync uut (
        .clk_bus(clk_bus), .clk_rtc(clk_rtc), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .status_o(status_o), .shadow_time_o(shadow_time_o), .shadow_date_o(shadow_date_o),
        .cfg_time_o(cfg_time_o), .cfg_date_o(cfg_date_o), .cfg_presc_o(cfg_presc_o),
        .cal_freeze_o(cal_freeze_o), .cal_tick_i(cal_tick_i),
        .cal_time_i(cal_time_i), .cal_date_i(cal_date_i));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk_bus);
        wr_en = 1; wr_sel = sel; wr_data = data;
        @(negedge clk_bus);
        wr_en = 0;
    endtask

    task automatic wait_status(input int b, input logic v, output bit hit);
        hit = 0;
        for (int i = 0; i < WAIT_MAX; i++) begin
            if (status_o[b] === v) begin hit = 1; break; end
            @(negedge clk_bus);
        end
    endtask

    task automatic rtc_tick(input logic [31:0] t, input logic [31:0] d);
        @(negedge clk_rtc);
        cal_time_i = t; cal_date_i = d; cal_tick_i = 1;
        @(negedge clk_rtc);
        cal_tick_i = 0;
    endtask

    initial begin
        #(BUS_PERIOD * 100000);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] t, d;
        repeat (3) @(negedge clk_bus);
        rst_n = 1;
        @(negedge clk_bus);
        // R1 reset state
        check("R1 status", {24'd0, status_o}, 32'd0);
        check("R1 shadow", shadow_time_o | shadow_date_o, 32'd0);
        check("R1 cfg", cfg_time_o | cfg_date_o | {9'd0, cfg_presc_o}, 32'd0);
        check("R1 freeze", {31'd0, cal_freeze_o}, 32'd0);

        // R3 writes ignored while not active
        bus_write(2'd1, 32'h0012_3456);
        bus_write(2'd3, 32'h0000_00FF);
        check("R3 ignored time", cfg_time_o, 32'd0);
        check("R3 ignored presc", {9'd0, cfg_presc_o}, 32'd0);

        // R6 shadow refresh sweep while running
        for (int i = 0; i < 6; i++) begin
            t = 32'h0001_0203 * (i + 1) ^ 32'h0015_0000;
            d = 32'h0102_0304 + 32'h0011_0101 * i;
            bus_write(2'd0, 32'h0);
            check("R5 cleared", {31'd0, status_o[5]}, 32'd0);
            rtc_tick(t, d);
            wait_status(5, 1'b1, ok);
            check("R6 synced rises", {31'd0, ok}, 32'd1);
            check("R6 shadow time", shadow_time_o, t);
            check("R6 shadow date", shadow_date_o, d);
        end

        // R5 writing one to synced has no effect
        bus_write(2'd0, 32'h0);
        bus_write(2'd0, 32'h20);
        check("R5 write one", {31'd0, status_o[5]}, 32'd0);

        // R2 enter freeze
        bus_write(2'd0, 32'h80);
        check("R2 request bit", {31'd0, status_o[7]}, 32'd1);
        check("R2 active not immediate", {31'd0, status_o[6]}, 32'd0);
        wait_status(6, 1'b1, ok);
        check("R2 active rises", {31'd0, ok}, 32'd1);
        check("R2 freeze high", {31'd0, cal_freeze_o}, 32'd1);
        check("R1 low bits zero", {28'd0, status_o[3:0]}, 32'd0);

        // R9 zero year does not set initialized
        bus_write(2'd2, 32'h0000_0A15);
        check("R3 date taken", cfg_date_o, 32'h0000_0A15);
        check("R9 zero year", {31'd0, status_o[4]}, 32'd0);

        // R3 accepted writes sweep
        for (int i = 0; i < 8; i++) begin
            t = (32'h0101_0101 * i) ^ 32'h0012_3456;
            bus_write(2'd1, t);
            check("R3 time", cfg_time_o, t);
            bus_write(2'd3, ~t);
            check("R3 presc", {9'd0, cfg_presc_o}, {9'd0, ~t[22:0]});
        end

        // R9 nonzero year sets initialized
        bus_write(2'd2, 32'h0024_0615);
        check("R9 nonzero year", {31'd0, status_o[4]}, 32'd1);

        // R7 ticks ignored while frozen
        bus_write(2'd0, 32'h80);
        t = 32'h0023_5959; d = 32'h0099_1231;
        t = t; d = d;
        check("R5 clear frozen", {31'd0, status_o[5]}, 32'd0);
        rtc_tick(32'h0023_5959, 32'h0099_1231);
        repeat (WAIT_MAX) @(negedge clk_bus);
        check("R7 synced stays", {31'd0, status_o[5]}, 32'd0);
        check("R7 shadow kept", shadow_time_o, 32'h0001_0203 * 6 ^ 32'h0015_0000);

        // R4/R8 exit freeze
        bus_write(2'd0, 32'h0);
        wait_status(6, 1'b0, ok);
        check("R4 active falls", {31'd0, ok}, 32'd1);
        check("R4 freeze low", {31'd0, cal_freeze_o}, 32'd0);
        wait_status(5, 1'b1, ok);
        check("R8 exit sync", {31'd0, ok}, 32'd1);
        check("R8 exit time", shadow_time_o, 32'h0023_5959);
        check("R8 exit date", shadow_date_o, 32'h0099_1231);

        // R3 ignored after exit
        bus_write(2'd1, 32'h0000_0001);
        check("R3 ignored after exit", cfg_time_o, (32'h0101_0101 * 7) ^ 32'h0012_3456);

        // R9 sticky across re-init with zero year
        bus_write(2'd0, 32'h80);
        wait_status(6, 1'b1, ok);
        bus_write(2'd2, 32'h0000_0101);
        check("R9 sticky", {31'd0, status_o[4]}, 32'd1);
        bus_write(2'd0, 32'h0);
        wait_status(6, 1'b0, ok);
        check("R9 sticky after exit", {31'd0, status_o[4]}, 32'd1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule